// File: doc/BRIEF.md
# Boot-Block Swap Address Remapper

This block sits on the address path between the processor and the firmware flash. On request it exchanges the highest 64 KB block of the flash window with the 64 KB block directly below it. Firmware can then rewrite its own boot code without risk. The sequence is: copy the boot block down one block, verify the copy, turn swapping on, rewrite the top block, verify it, and turn swapping off. If power fails while swapping is on, the platform still boots from the verified copy. This works because the enable bit is cleared only by the battery-backed reset. The ordinary platform reset leaves it unchanged.

Swapping is in effect when the software-written enable bit is 1 or when a board strap forces it. The strap level is captured while either reset is asserted and is held at that value afterwards. When the strap forces swapping, software cannot switch it off. The address path is combinational. Bit 16 of a BIOS-space address is inverted when swapping is in effect and the address lies in the top 128 KB of the 32-bit space. Every other address, and every feature-space cycle, passes through unchanged.

Top module: `boot_swap_remap`

## Requirements
- R1: While `rtc_rst_n` is low at a rising clock edge, the software swap bit becomes 0 from the next cycle. With the strap latched low, `swap_active` then reads 0.
- R2: A `plat_rst_n` pulse with `rtc_rst_n` high leaves the software swap bit at its previous value. A bit that was set before the pulse still reads 1 through `swap_active` afterwards.
- R3: With both resets high, `wr_en` high at a rising edge loads `wr_bit` into the swap bit, and the new value is used from the next cycle. A write presented while either reset is low is ignored. In the cycle of the write, the remap still uses the old value.
- R4: The strap input is captured at every rising edge where either reset is low, and it is held when both are high. A change on the strap pin during operation has no effect until the next reset.
- R5: `swap_active` is 1 exactly when the latched strap or the software swap bit is 1.
- R6: When swapping is in effect, `cyc_bios` is 1, and the address is at or above FFFE_0000, the output has bit 16 inverted and all other bits unchanged. FFFF_xxxx maps to FFFE_xxxx and FFFE_xxxx maps to FFFF_xxxx.
- R7: Addresses below FFFE_0000 pass through unchanged in every state.
- R8: With `cyc_bios` at 0 (feature space), the address passes through unchanged in every state.
- R9: With swapping not in effect, every address passes through unchanged.
- R10: While the strap is latched high, a software write of 0 leaves `swap_active` at 1 and the remap in effect. Forced mode ends only when a reset captures the strap pin low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Battery-well reset, active low, synchronous; clears the swap bit |
| plat_rst_n | input | 1 | Platform reset, active low, synchronous; recaptures only the strap |
| strap_force | input | 1 | Board strap that forces swap mode when captured high |
| wr_en | input | 1 | Write strobe for the swap bit |
| wr_bit | input | 1 | Value written to the swap bit |
| cpu_addr | input | 32 | Processor memory address |
| cyc_bios | input | 1 | 1 = BIOS-space cycle, 0 = feature-space cycle |
| flash_addr | output | 32 | Address forwarded to the flash |
| swap_active | output | 1 | Readable swap status, 1 when swapping is in effect |

## Verification
A register write and an address lookup can fall in the same cycle. The bench presents a top-block BIOS address together with a write that sets the bit. It then checks that the output is still unswapped before the edge and inverted in bit 16 in the following cycle. The same collision is provoked between a write and a platform reset pulse, where the write must be lost and the stored bit kept. Around each case, sweeps cover the block boundaries, feature cycles and near-miss upper patterns. Expected addresses are computed by adding or subtracting 64 KB.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    // Stored control state of the swap logic.
    typedef struct packed {
        logic swap;   // software-written enable, battery-well domain
        logic strap;  // strap level captured during reset
    } tbs_state_t;

endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
    import tbs_pkg::*;
(
    input  logic clk,
    input  logic rtc_rst_n,
    input  logic plat_rst_n,
    input  logic strap_pin,
    input  logic wr_en,
    input  logic wr_bit,
    output logic swap_active
);

    tbs_state_t st_d, st_q;
    logic       any_rst;

    assign any_rst = !rtc_rst_n || !plat_rst_n;

    always_comb begin
        st_d = st_q;
        if (any_rst) begin
            st_d.strap = strap_pin;
        end else if (wr_en) begin
            st_d.swap = wr_bit;
        end
        if (!rtc_rst_n) begin
            st_d.swap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign swap_active = st_q.swap | st_q.strap;

    // R1: battery-well reset clears the stored bit
    p_rtc_clear_r1: assert property (@(posedge clk)
        !rtc_rst_n |=> !st_q.swap);

    // R2: platform reset leaves the stored bit alone
    p_plat_keep_r2: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        !plat_rst_n |=> st_q.swap == $past(st_q.swap));

    // R3: a write outside reset lands on the next cycle
    p_write_r3: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        (plat_rst_n && wr_en) |=> st_q.swap == $past(wr_bit));

    // R4: strap value is frozen outside reset
    p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        plat_rst_n |=> st_q.strap == $past(st_q.strap));

    // R10: forced mode survives a software clear
    p_forced_r10: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        (plat_rst_n && st_q.strap) |=> swap_active);

endmodule

// File: rtl/tbs_remap.sv
module tbs_remap #(
    parameter int ADDR_W   = 32,
    parameter int FLIP_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              bios,
    input  logic              en,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - FLIP_BIT - 1;
    localparam logic [ADDR_W-1:0] TOP_BASE = {{HI_W{1'b1}}, {(FLIP_BIT + 1){1'b0}}};

    logic in_top;
    logic flip;

    always_comb begin
        in_top   = &addr_in[ADDR_W-1:FLIP_BIT+1];
        flip     = en && bios && in_top;
        addr_out = addr_in;
        addr_out[FLIP_BIT] = addr_in[FLIP_BIT] ^ flip;
    end

    // R6: inside the swap window the selecting bit changes
    p_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bios && addr_in >= TOP_BASE) |-> addr_out[FLIP_BIT] != addr_in[FLIP_BIT]);

    // R6: no bit other than the selecting one ever changes
    p_others_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_out ^ addr_in) == (addr_out[FLIP_BIT] ^ addr_in[FLIP_BIT]) << FLIP_BIT);

    // R7: below the window nothing changes
    p_low_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_in < TOP_BASE) |-> addr_out == addr_in);

    // R8: feature-space cycles pass through
    p_feature_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bios |-> addr_out == addr_in);

    // R9: swap disabled means identity
    p_off_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> addr_out == addr_in);

endmodule

// File: rtl/boot_swap_remap.sv
module boot_swap_remap #(
    parameter int ADDR_W   = 32,
    parameter int FLIP_BIT = 16
) (
    input  logic              clk,
    input  logic              rtc_rst_n,
    input  logic              plat_rst_n,
    input  logic              strap_force,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cyc_bios,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              swap_active
);

    logic active;

    tbs_ctrl u_ctrl (
        .clk         (clk),
        .rtc_rst_n   (rtc_rst_n),
        .plat_rst_n  (plat_rst_n),
        .strap_pin   (strap_force),
        .wr_en       (wr_en),
        .wr_bit      (wr_bit),
        .swap_active (active)
    );

    tbs_remap #(
        .ADDR_W   (ADDR_W),
        .FLIP_BIT (FLIP_BIT)
    ) u_remap (
        .clk      (clk),
        .rst_n    (rtc_rst_n),
        .addr_in  (cpu_addr),
        .bios     (cyc_bios),
        .en       (active),
        .addr_out (flash_addr)
    );

    assign swap_active = active;

endmodule

// File: tb/boot_swap_remap_tb_top.sv
module boot_swap_remap_tb_top;

    logic        clk = 1'b0;
    logic        rtc_rst_n = 1'b0;
    logic        plat_rst_n = 1'b0;
    logic        strap_force = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bit = 1'b0;
    logic [31:0] cpu_addr = 32'h0;
    logic        cyc_bios = 1'b0;
    logic [31:0] flash_addr;
    logic        swap_active;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    boot_swap_remap dut_i (
        .clk         (clk),
        .rtc_rst_n   (rtc_rst_n),
        .plat_rst_n  (plat_rst_n),
        .strap_force (strap_force),
        .wr_en       (wr_en),
        .wr_bit      (wr_bit),
        .cpu_addr    (cpu_addr),
        .cyc_bios    (cyc_bios),
        .flash_addr  (flash_addr),
        .swap_active (swap_active)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_status(input string tag, input logic exp);
        check(swap_active === exp, tag, {31'b0, swap_active}, {31'b0, exp});
    endtask

    function automatic logic [31:0] expect_addr(input logic [31:0] a, input bit eff, input bit bios);
        if (eff && bios && a >= 32'hFFFE_0000) begin
            if (a >= 32'hFFFF_0000) return a - 32'h0001_0000;
            else return a + 32'h0001_0000;
        end
        return a;
    endfunction

    task automatic probe(input logic [31:0] a, input bit bios, input bit eff);
        logic [31:0] e;
        string tag;
        @(negedge clk);
        cpu_addr = a;
        cyc_bios = bios;
        #2;
        e = expect_addr(a, eff, bios);
        if (!bios) tag = "R8 feature";
        else if (a < 32'hFFFE_0000) tag = "R7 below window";
        else if (eff) tag = "R6 swap window";
        else tag = "R9 swap off";
        check(flash_addr === e, tag, flash_addr, e);
    endtask

    task automatic sweep(input bit eff);
        logic [31:0] edges [8];
        edges[0] = 32'hFFFD_FFFF; edges[1] = 32'hFFFE_0000;
        edges[2] = 32'hFFFE_FFFF; edges[3] = 32'hFFFF_0000;
        edges[4] = 32'hFFFF_FFFF; edges[5] = 32'h0000_0000;
        edges[6] = 32'h7FFF_0000; edges[7] = 32'hFFFC_FFFF;
        for (int b = 0; b < 2; b++) begin
            for (int j = 0; j < 8; j++) probe(edges[j], b[0], eff);
            for (int k = 0; k < 64; k++)
                probe(32'hFFF8_0000 + k * 32'h2000 + ((k * 37) & 32'h1FFF), b[0], eff);
        end
    endtask

    task automatic do_write(input logic b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_bit = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic plat_pulse(input logic s);
        @(negedge clk);
        strap_force = s;
        plat_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        plat_rst_n = 1'b1;
    endtask

    task automatic rtc_pulse(input logic s);
        @(negedge clk);
        strap_force = s;
        rtc_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rtc_rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rtc_rst_n = 1'b1;
        plat_rst_n = 1'b1;
        @(negedge clk);
        check_status("R1 reset state", 1'b0);
        sweep(1'b0);

        // R3: write and lookup collide; old value used this cycle
        @(negedge clk);
        cpu_addr = 32'hFFFF_1234; cyc_bios = 1'b1; wr_en = 1'b1; wr_bit = 1'b1;
        #2;
        check(flash_addr === 32'hFFFF_1234, "R3 same-cycle old", flash_addr, 32'hFFFF_1234);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check(flash_addr === 32'hFFFE_1234, "R3 next-cycle new", flash_addr, 32'hFFFE_1234);
        check_status("R5 status after set", 1'b1);
        sweep(1'b1);

        // R2 plus R3: write of 0 during platform reset must be lost
        @(negedge clk);
        strap_force = 1'b0; plat_rst_n = 1'b0; wr_en = 1'b1; wr_bit = 1'b0;
        repeat (2) @(negedge clk);
        wr_en = 1'b0; plat_rst_n = 1'b1;
        @(negedge clk);
        check_status("R2 bit kept over platform reset", 1'b1);
        probe(32'hFFFE_00AA, 1'b1, 1'b1);

        // R1: battery reset clears
        rtc_pulse(1'b0);
        @(negedge clk);
        check_status("R1 battery reset clears", 1'b0);
        sweep(1'b0);

        // R4/R10: forced by strap
        plat_pulse(1'b1);
        @(negedge clk);
        check_status("R4 strap captured", 1'b1);
        do_write(1'b0);
        check_status("R10 clear ignored when forced", 1'b1);
        sweep(1'b1);
        @(negedge clk);
        strap_force = 1'b0;
        repeat (3) @(negedge clk);
        check_status("R4 pin change ignored", 1'b1);
        probe(32'hFFFF_8000, 1'b1, 1'b1);

        // R10: exit forced mode by reset with strap low
        plat_pulse(1'b0);
        @(negedge clk);
        check_status("R10 forced mode left", 1'b0);
        probe(32'hFFFF_8000, 1'b1, 1'b0);

        // R1: battery reset with strap high still reports active
        do_write(1'b1);
        rtc_pulse(1'b1);
        @(negedge clk);
        strap_force = 1'b0;
        check_status("R1 battery reset strap high", 1'b1);
        do_write(1'b0);
        check_status("R10 forced after battery reset", 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule